// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a byte-wide parallel flash array. It watches single-cycle write strobes that carry a 17-bit address and a byte of data, and it recognises the unlock sequences that guard every state-changing operation. A recognised sequence produces a one-cycle request to the array and timer logic: program a byte, erase the whole chip, or set the permanent boot-region lock. It also enters and leaves an identification mode that changes what reads return.

The lock flag stands in for a non-volatile bit. It is cleared only by the power-on reset `por_n`. The ordinary reset `rst_n` clears the sequence tracker and the identification mode, and it leaves the lock untouched. After the lock is set, the decoder drops program requests aimed at the low 8 KB. Erase requests still go out, but they tell the array to spare that region. While the array reports an operation in progress, every write is ignored.

Top module: `flash_cmd_decoder`

## Requirements
- R1: With `por_n` and `rst_n` low and then released, `prog_req`, `erase_req`, `id_mode` and `boot_locked` read 0, and `rd_data` equals `array_rdata`.
- R2: The writes AAh@5555h, 55h@2AAAh and A0h@5555h, followed by a fourth write (A, D), raise `prog_req` for exactly the one cycle after that fourth write. In that cycle `prog_addr`=A and `prog_wdata` = `prog_old_data` AND D.
- R3: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh and 10h@5555h raise `erase_req` for one cycle. In that cycle `erase_keep_boot` equals the lock state. A different final byte (other than 40h) raises nothing.
- R4: The same six writes ending in 40h@5555h set `boot_locked` one cycle after the request. Neither a later `rst_n` pulse nor repeating the sequence ever clears it.
- R5: While locked, a program whose target address is below 2000h raises no `prog_req`. A target of 2000h or above still raises it.
- R6: AAh@5555h, 55h@2AAAh, 90h@5555h sets `id_mode`. The same prefix followed by F0h@5555h clears it. A single F0h write to any address while no sequence is in progress also clears it.
- R7: In ID mode, `rd_data` is 1Fh at address 0, 17h at address 1, and {7'b0, lock} at address 2. Every other address reads 00h. Outside ID mode, `rd_data` follows `array_rdata`.
- R8: A write that does not match the expected step returns the tracker to idle and issues nothing. Later writes must restart from the first AAh.
- R9: A write made while `busy` is high is ignored. It issues nothing and does not advance or reset the tracker.
- R10: Matching against 5555h and 2AAAh uses only address bits 14:0. Bits 16:15 may hold any value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the sequence tracker and ID mode |
| por_n | input | 1 | Active-low power-on reset; the only way to clear the lock |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Write data |
| busy | input | 1 | Program or erase in progress; writes are ignored |
| prog_old_data | input | 8 | Current array byte at `prog_addr` |
| prog_req | output | 1 | One-cycle byte program request |
| prog_addr | output | 17 | Program target address |
| prog_wdata | output | 8 | Byte to store: old data AND new data |
| erase_req | output | 1 | One-cycle chip erase request |
| erase_keep_boot | output | 1 | Erase must spare the boot region |
| boot_locked | output | 1 | Boot-region lock state |
| id_mode | output | 1 | Identification mode active |
| rd_addr | input | 17 | Read address |
| array_rdata | input | 8 | Array read data |
| rd_data | output | 8 | Read data after ID multiplexing |

## Verification
Two functions can fall in the same cycle: the final write of a sequence and the busy interlock. The bench raises `busy` in exactly the cycle of the fourth program write. It then checks that no request appears and that the tracker is still waiting, so the same write repeated with `busy` low must produce the request. A second overlap is the lock being set while ID mode is active. In that case the status byte at address 2 must change from 00h to 01h with no exit from ID mode. Sweeping every final byte of the six-write sequence confirms that only 10h erases.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam logic [7:0] CMD_KEY_A   = 8'hAA;
    localparam logic [7:0] CMD_KEY_B   = 8'h55;
    localparam logic [7:0] CMD_PROGRAM = 8'hA0;
    localparam logic [7:0] CMD_ERS_SET = 8'h80;
    localparam logic [7:0] CMD_ERS_ALL = 8'h10;
    localparam logic [7:0] CMD_LOCK    = 8'h40;
    localparam logic [7:0] CMD_ID_IN   = 8'h90;
    localparam logic [7:0] CMD_ID_OUT  = 8'hF0;

    localparam logic [15:0] KEY_ADDR_A = 16'h5555;
    localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;

    typedef enum logic [2:0] {
        S_IDLE, S_KEY1, S_KEY2, S_PROG, S_ERS1, S_ERS2, S_ERS3
    } seq_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_PROG, OP_ERASE, OP_LOCK, OP_ID_IN, OP_ID_OUT
    } op_e;

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
    import fcd_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int MATCH_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              busy,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output op_e               op,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data
);

    typedef struct packed {
        seq_e              state;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } seq_t;

    seq_t d, q;
    logic hit_a, hit_b;

    assign hit_a = (wr_addr[MATCH_W-1:0] == KEY_ADDR_A[MATCH_W-1:0]);
    assign hit_b = (wr_addr[MATCH_W-1:0] == KEY_ADDR_B[MATCH_W-1:0]);

    always_comb begin
        d    = q;
        d.op = OP_NONE;
        if (wr_en && !busy) begin
            d.state = S_IDLE;
            unique case (q.state)
                S_IDLE: begin
                    if (hit_a && wr_data == CMD_KEY_A) d.state = S_KEY1;
                    else if (wr_data == CMD_ID_OUT)    d.op    = OP_ID_OUT;
                end
                S_KEY1: if (hit_b && wr_data == CMD_KEY_B) d.state = S_KEY2;
                S_KEY2: begin
                    if (hit_a) begin
                        case (wr_data)
                            CMD_PROGRAM: d.state = S_PROG;
                            CMD_ERS_SET: d.state = S_ERS1;
                            CMD_ID_IN:   d.op    = OP_ID_IN;
                            CMD_ID_OUT:  d.op    = OP_ID_OUT;
                            default:     d.state = S_IDLE;
                        endcase
                    end
                end
                S_PROG: begin
                    d.op   = OP_PROG;
                    d.addr = wr_addr;
                    d.data = wr_data;
                end
                S_ERS1: if (hit_a && wr_data == CMD_KEY_A) d.state = S_ERS2;
                S_ERS2: if (hit_b && wr_data == CMD_KEY_B) d.state = S_ERS3;
                S_ERS3: begin
                    if (hit_a && wr_data == CMD_ERS_ALL)   d.op = OP_ERASE;
                    else if (hit_a && wr_data == CMD_LOCK) d.op = OP_LOCK;
                end
                default: d.state = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{state: S_IDLE, op: OP_NONE, addr: '0, data: '0};
        else        q <= d;
    end

    assign op      = q.op;
    assign op_addr = q.addr;
    assign op_data = q.data;

    // R8: an issued operation leaves the tracker idle
    a_r8_idle_after_op: assert property (@(posedge clk) disable iff (!rst_n)
        (q.op != OP_NONE) |-> (q.state == S_IDLE));

endmodule

// File: rtl/fcd_guard.sv
module fcd_guard
    import fcd_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int BOOT_BYTES = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  op_e               op,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        op_data,
    input  logic [7:0]        prog_old_data,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        prog_wdata,
    output logic              erase_req,
    output logic              erase_keep_boot,
    output logic              boot_locked,
    output logic              id_mode
);

    localparam logic [ADDR_W-1:0] BOOT_END = ADDR_W'(BOOT_BYTES);

    typedef struct packed {
        logic id_mode;
    } mode_t;

    mode_t mode_d, mode_q;
    logic  lock_d, lock_q;
    logic  in_boot;

    assign in_boot = (op_addr < BOOT_END);

    always_comb begin
        mode_d = mode_q;
        lock_d = lock_q;
        if (op == OP_ID_IN)  mode_d.id_mode = 1'b1;
        if (op == OP_ID_OUT) mode_d.id_mode = 1'b0;
        if (op == OP_LOCK)   lock_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= '{id_mode: 1'b0};
        else        mode_q <= mode_d;
    end

    always_ff @(posedge clk) begin
        if (!por_n) lock_q <= 1'b0;
        else        lock_q <= lock_d;
    end

    assign prog_req        = (op == OP_PROG) && !(lock_q && in_boot);
    assign prog_addr       = op_addr;
    assign prog_wdata      = prog_old_data & op_data;
    assign erase_req       = (op == OP_ERASE);
    assign erase_keep_boot = lock_q;
    assign boot_locked     = lock_q;
    assign id_mode         = mode_q.id_mode;

    // R4: the lock never falls outside power-on reset
    a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!por_n)
        lock_q |=> lock_q);

    // R5: no program request reaches the boot region once locked
    a_r5_boot_fenced: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (prog_req && lock_q) |-> (prog_addr >= BOOT_END));

endmodule

// File: rtl/fcd_rdmux.sv
module fcd_rdmux #(
    parameter int          ADDR_W = 17,
    parameter logic [7:0]  MFR_ID = 8'h1F,
    parameter logic [7:0]  DEV_ID = 8'h17
) (
    input  logic              id_mode,
    input  logic              boot_locked,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        array_rdata,
    output logic [7:0]        rd_data
);

    logic [7:0] id_byte;

    always_comb begin
        case (rd_addr)
            ADDR_W'(0): id_byte = MFR_ID;
            ADDR_W'(1): id_byte = DEV_ID;
            ADDR_W'(2): id_byte = {7'b0, boot_locked};
            default:    id_byte = 8'h00;
        endcase
        rd_data = id_mode ? id_byte : array_rdata;
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int         ADDR_W     = 17,
    parameter int         MATCH_W    = 15,
    parameter int         BOOT_BYTES = 8192,
    parameter logic [7:0] MFR_ID     = 8'h1F,
    parameter logic [7:0] DEV_ID     = 8'h17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    input  logic [7:0]        prog_old_data,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        prog_wdata,
    output logic              erase_req,
    output logic              erase_keep_boot,
    output logic              boot_locked,
    output logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        array_rdata,
    output logic [7:0]        rd_data
);

    op_e               op;
    logic [ADDR_W-1:0] op_addr;
    logic [7:0]        op_data;

    fcd_seq #(.ADDR_W(ADDR_W), .MATCH_W(MATCH_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .op(op), .op_addr(op_addr), .op_data(op_data)
    );

    fcd_guard #(.ADDR_W(ADDR_W), .BOOT_BYTES(BOOT_BYTES)) u_guard (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .op(op), .op_addr(op_addr), .op_data(op_data),
        .prog_old_data(prog_old_data),
        .prog_req(prog_req), .prog_addr(prog_addr), .prog_wdata(prog_wdata),
        .erase_req(erase_req), .erase_keep_boot(erase_keep_boot),
        .boot_locked(boot_locked), .id_mode(id_mode)
    );

    fcd_rdmux #(.ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rdmux (
        .id_mode(id_mode), .boot_locked(boot_locked), .rd_addr(rd_addr),
        .array_rdata(array_rdata), .rd_data(rd_data)
    );

    // R2: a program request lasts a single cycle
    a_r2_prog_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req);

    // R3: erase and program are never requested together
    a_r3_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_req, erase_req}));

    // R9: a write under busy issues nothing
    a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> (!prog_req && !erase_req));

endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, por_n, wr_en, busy;
    logic [16:0] wr_addr, rd_addr;
    logic [7:0]  wr_data, prog_old_data, array_rdata, rd_data, prog_wdata;
    logic        prog_req, erase_req, erase_keep_boot, boot_locked, id_mode;
    logic [16:0] prog_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign prog_old_data = prog_addr[7:0] ^ prog_addr[15:8] ^ 8'h3C;
    assign array_rdata   = rd_addr[7:0] + 8'h11;

    flash_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy),
        .prog_old_data(prog_old_data), .prog_req(prog_req),
        .prog_addr(prog_addr), .prog_wdata(prog_wdata),
        .erase_req(erase_req), .erase_keep_boot(erase_keep_boot),
        .boot_locked(boot_locked), .id_mode(id_mode),
        .rd_addr(rd_addr), .array_rdata(array_rdata), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [16:0] a, input logic [7:0] dat);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = dat;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic prefix();
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h55);
    endtask

    task automatic six(input logic [7:0] last);
        prefix(); wr(17'h05555, 8'h80);
        prefix(); wr(17'h05555, last);
    endtask

    task automatic rd_chk(input string tag, input logic [16:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [16:0] a;
        logic [7:0]  old;
        rst_n = 0; por_n = 0; wr_en = 0; busy = 0;
        wr_addr = '0; wr_data = '0; rd_addr = 17'h00123;
        repeat (3) @(negedge clk);
        rst_n = 1; por_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 prog_req", prog_req, 0);
        chk("R1 erase_req", erase_req, 0);
        chk("R1 id_mode", id_mode, 0);
        chk("R1 boot_locked", boot_locked, 0);
        rd_chk("R1 rd_data", 17'h00123, 8'h34);

        // R2 program sweep over all data values
        for (int i = 0; i < 256; i++) begin
            a = 17'h04000 + 17'(i * 37);
            prefix(); wr(17'h05555, 8'hA0); wr(a, 8'(i));
            old = a[7:0] ^ a[15:8] ^ 8'h3C;
            chk("R2 prog_req", prog_req, 1);
            chk("R2 prog_addr", prog_addr, a);
            chk("R2 prog_wdata", prog_wdata, old & 8'(i));
            @(negedge clk);
            chk("R2 pulse end", prog_req, 0);
        end

        // R3 / R8 sweep of the final erase byte (lock code skipped)
        for (int c = 0; c < 256; c++) begin
            if (c != 8'h40) begin
                six(8'(c));
                chk("R3 erase_req", erase_req, (c == 8'h10) ? 1 : 0);
                if (c == 8'h10) chk("R3 keep_boot unlocked", erase_keep_boot, 0);
                chk("R8 no program", prog_req, 0);
            end
        end
        chk("R4 still unlocked", boot_locked, 0);

        // R6 / R7 ID mode
        prefix(); wr(17'h05555, 8'h90);
        @(negedge clk);
        chk("R6 id entry", id_mode, 1);
        rd_chk("R7 mfr", 17'h00000, 8'h1F);
        rd_chk("R7 dev", 17'h00001, 8'h17);
        rd_chk("R7 lock unlocked", 17'h00002, 8'h00);
        rd_chk("R7 other", 17'h00003, 8'h00);
        rd_chk("R7 high", 17'h10000, 8'h00);
        prefix(); wr(17'h05555, 8'hF0);
        @(negedge clk);
        chk("R6 id exit long", id_mode, 0);
        rd_chk("R7 array", 17'h00001, 8'h12);
        prefix(); wr(17'h05555, 8'h90);
        wr(17'h12345, 8'hF0);
        @(negedge clk);
        chk("R6 id exit single", id_mode, 0);

        // R8 mismatches
        wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h56);
        wr(17'h05555, 8'hA0); wr(17'h06000, 8'h12);
        chk("R8 broken prefix", prog_req, 0);
        prefix(); wr(17'h05555, 8'h80); wr(17'h05554, 8'hAA);
        wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h10);
        chk("R8 broken erase", erase_req, 0);

        // R10 upper address bits ignored in matching
        wr(17'h15555, 8'hAA); wr(17'h0AAAA, 8'h55); wr(17'h1D555, 8'hA0);
        wr(17'h0A000, 8'h0F);
        chk("R10 upper bits ignored", prog_req, 1);

        // R9 busy in the cycle of the final write
        prefix(); wr(17'h05555, 8'hA0);
        busy = 1;
        wr(17'h07000, 8'h55);
        chk("R9 busy blocks", prog_req, 0);
        busy = 0;
        wr(17'h07000, 8'h55);
        chk("R9 tracker held", prog_req, 1);

        // R4 lock while in ID mode
        prefix(); wr(17'h05555, 8'h90);
        six(8'h40);
        chk("R4 no erase on lock", erase_req, 0);
        @(negedge clk);
        chk("R4 locked", boot_locked, 1);
        rd_chk("R7 lock status", 17'h00002, 8'h01);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk("R4 survives reset", boot_locked, 1);
        chk("R1 reset clears id", id_mode, 0);
        six(8'h40);
        @(negedge clk);
        chk("R4 repeat keeps", boot_locked, 1);

        // R5 boot fence
        prefix(); wr(17'h05555, 8'hA0); wr(17'h01FFF, 8'h00);
        chk("R5 top of boot", prog_req, 0);
        prefix(); wr(17'h05555, 8'hA0); wr(17'h00000, 8'h00);
        chk("R5 base of boot", prog_req, 0);
        prefix(); wr(17'h05555, 8'hA0); wr(17'h02000, 8'h00);
        chk("R5 first main byte", prog_req, 1);

        // R3 erase while locked
        six(8'h10);
        chk("R3 erase locked", erase_req, 1);
        chk("R3 keep_boot locked", erase_keep_boot, 1);

        done = 1;
        summary();
        $finish;
    end

endmodule